// File: doc/BRIEF.md
# Keyboard and Mouse Host Interface

This block sits between a host I/O bus and an embedded core and presents the classic keyboard controller register pair to the host. The host sees two ports. The data port is selected when `host_a2` is 0. The command/status port is selected when `host_a2` is 1. Host writes to either port land in a single input byte for the core. The tag bit records which port received the write.

The core answers by writing an output byte on the keyboard path or on the mouse path. Either write raises the output-full flag and a level interrupt line toward the host: `irq1` for the keyboard path and `irq12` for the mouse path. The flag drops when the host reads the data port.

The core can also do the following:
- force the output flag clear;
- set or clear the free status bits;
- take an interrupt when the input byte is full;
- take an interrupt when the output byte has been consumed.

The hardware-owned status bits cannot be altered by those flag writes.

Top module: `kbd_host_if`

## Requirements
- R1: A host write (`host_wr`) latches `host_wdata` into `core_in_data`, sets IBF (status bit 1) and stores `host_a2` in status bit 3 (1 = command port, 0 = data port). All of this is visible after the next clock edge.
- R2: A host write while IBF is already 1 replaces the latched byte and the bit-3 tag, and IBF remains 1.
- R3: A core read of the input byte (`core_ibuf_rd`) clears IBF. When a host write falls in the same cycle, the write wins and IBF is 1 afterwards.
- R4: A core keyboard write (`core_kbd_wr`) loads the output byte and sets OBF (status bit 0). While OBF is 1 from a keyboard write, `irq1` is active and `irq12` is inactive.
- R5: A core mouse write (`core_mse_wr`) does the same with `irq12` active and `irq1` inactive. When both writes fall in one cycle, the keyboard write is taken.
- R6: A host read (`host_rd`) of the data port clears OBF and drops the active legacy IRQ. A host read of the status port leaves OBF unchanged. A core output write in the same cycle as a data-port read wins, so OBF stays 1.
- R7: `core_obf_clr` clears OBF, and with it the IRQ. A core output write in the same cycle wins.
- R8: `core_flag_set` ORs `core_flag_mask` into the user status bits 2, 4, 5, 6 and 7. `core_flag_clr` removes the masked bits, and clear wins over set. Neither operation changes bits 0, 1 or 3.
- R9: `core_ibf_irq` equals `core_ibf_ie` AND IBF. `core_obe_irq` equals `core_obe_ie` AND NOT OBF.
- R10: `host_rdata` combinationally returns the status byte when `host_a2` is 1 and the output byte when it is 0.
- R11: After reset, the status, input byte and output byte are all 0, and both legacy IRQs are inactive. The active level is high with the default `IRQ_ACT_HIGH` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_a2 | input | 1 | Port select: 1 command/status, 0 data |
| host_wdata | input | DW | Host write byte |
| host_rdata | output | DW | Host read byte |
| core_ibuf_rd | input | 1 | Core read of the input byte, clears IBF |
| core_in_data | output | DW | Latched host byte |
| core_kbd_wr | input | 1 | Core keyboard output write |
| core_mse_wr | input | 1 | Core mouse output write |
| core_wdata | input | DW | Core output byte |
| core_obf_clr | input | 1 | Force OBF clear |
| core_flag_set | input | 1 | Set masked user flags |
| core_flag_clr | input | 1 | Clear masked user flags |
| core_flag_mask | input | 8 | User flag mask |
| core_ibf_ie | input | 1 | Input-full interrupt enable |
| core_obe_ie | input | 1 | Output-empty interrupt enable |
| status | output | 8 | Status byte (bit0 OBF, bit1 IBF, bit3 A2) |
| irq1 | output | 1 | Keyboard legacy IRQ, level |
| irq12 | output | 1 | Mouse legacy IRQ, level |
| core_ibf_irq | output | 1 | Core input-full interrupt |
| core_obe_irq | output | 1 | Core output-empty interrupt |

## Verification
Two pairs of events can collide in one cycle:
- a host write and a core read of the input byte;
- a host read of the data port and a core output write.

Each pair is driven deliberately in directed steps, and the result is judged on IBF or OBF one edge later. In both cases the setting event must survive. The random phase then raises every strobe independently, so these collisions recur alongside flag writes and force-clears. A behavioural model settles each outcome by the stated priorities.

// File: rtl/kbd_host_if.sv
module kbd_host_if #(
  parameter int DW = 8,
  parameter bit IRQ_ACT_HIGH = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_a2,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          core_ibuf_rd,
  output logic [DW-1:0] core_in_data,
  input  logic          core_kbd_wr,
  input  logic          core_mse_wr,
  input  logic [DW-1:0] core_wdata,
  input  logic          core_obf_clr,
  input  logic          core_flag_set,
  input  logic          core_flag_clr,
  input  logic [7:0]    core_flag_mask,
  input  logic          core_ibf_ie,
  input  logic          core_obe_ie,
  output logic [7:0]    status,
  output logic          irq1,
  output logic          irq12,
  output logic          core_ibf_irq,
  output logic          core_obe_irq
);
  localparam logic [7:0] USER_BITS = 8'hF4;

  logic          ibf, obf, tag, from_mse;
  logic [DW-1:0] in_q, out_q;
  logic [7:0]    flags;
  logic          out_wr;

  assign out_wr = core_kbd_wr | core_mse_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibf  <= 1'b0;
      tag  <= 1'b0;
      in_q <= '0;
    end else if (host_wr) begin
      ibf  <= 1'b1;
      tag  <= host_a2;
      in_q <= host_wdata;
    end else if (core_ibuf_rd) begin
      ibf  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obf      <= 1'b0;
      from_mse <= 1'b0;
      out_q    <= '0;
    end else if (out_wr) begin
      obf      <= 1'b1;
      from_mse <= ~core_kbd_wr;
      out_q    <= core_wdata;
    end else if (core_obf_clr || (host_rd && !host_a2)) begin
      obf      <= 1'b0;
    end
  end

  logic [7:0] flags_set;
  assign flags_set = core_flag_set ? (flags | core_flag_mask) : flags;

  always_ff @(posedge clk) begin
    if (!rst_n)
      flags <= '0;
    else if (core_flag_set || core_flag_clr)
      flags <= (core_flag_clr ? (flags_set & ~core_flag_mask) : flags_set) & USER_BITS;
  end

  assign status       = {flags[7:4], tag, flags[2], ibf, obf};
  assign core_in_data = in_q;
  assign host_rdata   = host_a2 ? DW'(status) : out_q;

  assign irq1         = (obf & ~from_mse) ^ ~IRQ_ACT_HIGH;
  assign irq12        = (obf &  from_mse) ^ ~IRQ_ACT_HIGH;
  assign core_ibf_irq = core_ibf_ie & ibf;
  assign core_obe_irq = core_obe_ie & ~obf;
endmodule

module kbd_host_if_chk #(
  parameter bit IRQ_ACT_HIGH = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_rd,
  input logic       host_a2,
  input logic       core_ibuf_rd,
  input logic       core_kbd_wr,
  input logic       core_mse_wr,
  input logic       core_obf_clr,
  input logic       core_flag_set,
  input logic       core_flag_clr,
  input logic [7:0] status,
  input logic       irq1,
  input logic       irq12
);
  a_r1_wr_sets_ibf: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> status[1]);

  a_r3_rd_clears_ibf: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ibuf_rd && !host_wr) |=> !status[1]);

  a_r4_kbd_irq: assert property (@(posedge clk) disable iff (!rst_n)
    core_kbd_wr |=> (irq1 == IRQ_ACT_HIGH) && (irq12 != IRQ_ACT_HIGH));

  a_r5_mse_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (core_mse_wr && !core_kbd_wr) |=> (irq12 == IRQ_ACT_HIGH) && (irq1 != IRQ_ACT_HIGH));

  a_r6_host_rd_clears_obf: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_a2 && !core_kbd_wr && !core_mse_wr) |=> !status[0]);

  a_r8_hw_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_flag_set || core_flag_clr) && !host_wr && !core_ibuf_rd && !host_rd &&
     !core_kbd_wr && !core_mse_wr && !core_obf_clr)
    |=> $stable(status[1:0]) && $stable(status[3]));

  a_r4_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !((irq1 == IRQ_ACT_HIGH) && (irq12 == IRQ_ACT_HIGH)));
endmodule

bind kbd_host_if kbd_host_if_chk #(.IRQ_ACT_HIGH(IRQ_ACT_HIGH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .host_a2(host_a2),
  .core_ibuf_rd(core_ibuf_rd), .core_kbd_wr(core_kbd_wr), .core_mse_wr(core_mse_wr),
  .core_obf_clr(core_obf_clr), .core_flag_set(core_flag_set), .core_flag_clr(core_flag_clr),
  .status(status), .irq1(irq1), .irq12(irq12)
);

// File: tb/kbd_host_if_test.sv
`timescale 1ns/1ps
module kbd_host_if_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       host_wr = 0, host_rd = 0, host_a2 = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic       core_ibuf_rd = 0;
  logic [7:0] core_in_data;
  logic       core_kbd_wr = 0, core_mse_wr = 0;
  logic [7:0] core_wdata = 0;
  logic       core_obf_clr = 0, core_flag_set = 0, core_flag_clr = 0;
  logic [7:0] core_flag_mask = 0;
  logic       core_ibf_ie = 0, core_obe_ie = 0;
  logic [7:0] status;
  logic       irq1, irq12, core_ibf_irq, core_obe_irq;

  kbd_host_if uut (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  // reference state
  bit m_ibf, m_obf, m_a2, m_mse;
  logic [7:0] m_in, m_out, m_flags;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {m_flags[7:4], m_a2, m_flags[2], m_ibf, m_obf};
  endfunction

  task automatic model_step();
    if (host_wr) begin m_ibf = 1; m_in = host_wdata; m_a2 = host_a2; end
    else if (core_ibuf_rd) m_ibf = 0;
    if (core_kbd_wr || core_mse_wr) begin m_obf = 1; m_out = core_wdata; m_mse = !core_kbd_wr; end
    else if (core_obf_clr || (host_rd && !host_a2)) m_obf = 0;
    if (core_flag_set) m_flags = m_flags | core_flag_mask;
    if (core_flag_clr) m_flags = m_flags & ~core_flag_mask;
    m_flags = m_flags & 8'hF4;
  endtask

  task automatic compare();
    logic [7:0] exp_rd;
    exp_rd = host_a2 ? m_status() : m_out;
    chk(status == m_status(), "R1 status", status, m_status());
    chk(core_in_data == m_in, "R1 in_data", core_in_data, m_in);
    chk(host_rdata == exp_rd, "R10 host_rdata", host_rdata, exp_rd);
    chk(irq1 == (m_obf && !m_mse), "R4 irq1", irq1, m_obf && !m_mse);
    chk(irq12 == (m_obf && m_mse), "R5 irq12", irq12, m_obf && m_mse);
    chk(core_ibf_irq == (core_ibf_ie && m_ibf), "R9 ibf_irq", core_ibf_irq, core_ibf_ie && m_ibf);
    chk(core_obe_irq == (core_obe_ie && !m_obf), "R9 obe_irq", core_obe_irq, core_obe_ie && !m_obf);
  endtask

  // inputs held over one edge, then model advanced and outputs compared
  task automatic tick();
    @(posedge clk);
    #2;
    model_step();
    compare();
    {host_wr, host_rd, core_ibuf_rd, core_kbd_wr, core_mse_wr} = '0;
    {core_obf_clr, core_flag_set, core_flag_clr} = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    {m_ibf, m_obf, m_a2, m_mse} = '0;
    m_in = 0; m_out = 0; m_flags = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk(status == 8'h00, "R11 reset status", status, 0);
    chk(!irq1 && !irq12, "R11 reset irqs", {irq1, irq12}, 0);
    chk(core_in_data == 0, "R11 reset in", core_in_data, 0);

    host_wr = 1; host_a2 = 0; host_wdata = 8'h5A; tick();
    chk(status[1] && !status[3] && core_in_data == 8'h5A, "R1 data write", status, 8'h02);
    host_wr = 1; host_a2 = 1; host_wdata = 8'hD4; tick();
    chk(status[1] && status[3] && core_in_data == 8'hD4, "R2 overwrite", status, 8'h0A);
    core_ibf_ie = 1; tick();
    chk(core_ibf_irq, "R9 ibf irq", core_ibf_irq, 1);
    core_ibuf_rd = 1; tick();
    chk(!status[1], "R3 core read clears", status[1], 0);
    host_wr = 1; host_a2 = 0; host_wdata = 8'h33; core_ibuf_rd = 1; tick();
    chk(status[1], "R3 collision host wins", status[1], 1);

    core_obe_ie = 1; core_kbd_wr = 1; core_wdata = 8'h11; tick();
    chk(status[0] && irq1 && !irq12 && !core_obe_irq, "R4 kbd out", {irq1, irq12}, 2);
    host_rd = 1; host_a2 = 1; tick();
    chk(status[0], "R6 status read keeps", status[0], 1);
    host_rd = 1; host_a2 = 0; tick();
    chk(!status[0] && !irq1 && core_obe_irq, "R6 data read clears", status[0], 0);
    core_mse_wr = 1; core_wdata = 8'h22; tick();
    chk(irq12 && !irq1, "R5 mse out", {irq1, irq12}, 1);
    core_kbd_wr = 1; core_mse_wr = 1; core_wdata = 8'h44; tick();
    chk(irq1 && !irq12, "R5 kbd priority", {irq1, irq12}, 2);
    host_rd = 1; host_a2 = 0; core_kbd_wr = 1; core_wdata = 8'h55; tick();
    chk(status[0], "R6 collision write wins", status[0], 1);
    core_obf_clr = 1; tick();
    chk(!status[0] && !irq1, "R7 force clear", status[0], 0);
    core_obf_clr = 1; core_mse_wr = 1; core_wdata = 8'h66; tick();
    chk(status[0] && irq12, "R7 write beats clear", status[0], 1);

    core_flag_set = 1; core_flag_mask = 8'hFF; tick();
    chk((status & 8'hF4) == 8'hF4 && status[1] && status[0] && !status[3], "R8 set flags", status, 8'hF7);
    core_flag_clr = 1; core_flag_mask = 8'hFF; tick();
    chk(status == 8'h03, "R8 clear flags", status, 8'h03);
    core_flag_set = 1; core_flag_clr = 1; core_flag_mask = 8'h10; tick();
    chk(status[4] == 0, "R8 clear wins", status[4], 0);

    for (int i = 0; i < 3000; i++) begin
      host_wr = ($urandom % 4) == 0; host_rd = ($urandom % 3) == 0; host_a2 = $urandom;
      host_wdata = $urandom; core_ibuf_rd = ($urandom % 3) == 0;
      core_kbd_wr = ($urandom % 5) == 0; core_mse_wr = ($urandom % 5) == 0;
      core_wdata = $urandom; core_obf_clr = ($urandom % 7) == 0;
      core_flag_set = ($urandom % 4) == 0; core_flag_clr = ($urandom % 4) == 0;
      core_flag_mask = $urandom; core_ibf_ie = $urandom; core_obe_ie = $urandom;
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule